// File: doc/BRIEF.md
# Template Fit Adaptation Sequencer

This block is the control side of a template matcher. An external distance engine compares a transformed input window with a stored template. It returns one squared-error figure for each evaluation it is asked to make. The sequencer decides which settings to try and in what order, and keeps the best result.

For each beat it first tries a small set of integer sample lags around the nominal alignment, with the transform held at unity, and keeps the lag with the lowest error. It then tunes the centre-tap amplitude code by bisection, and after that the outer-tap phase code by bisection. Each coefficient is handled on its own, with the other one held fixed.

A beat started in calibration mode adds its fitted error to a running sum. Once a programmed number of calibration beats has completed, the classification threshold becomes twice their mean. Each ordinary beat is then labelled safe or unknown against that threshold.

Top module: `adapt_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` pulses for one cycle; `done` and a low `busy` appear together. A `start` seen while `busy` is high has no effect on the running beat.
- R2: The lag search presents offsets in the order 0, -1, +1, -2, +2, ... up to ±LAG_RADIUS, one evaluation each. Throughout the search the amplitude and phase codes both hold the unity/zero code 2^(COEF_W-1).
- R3: The kept lag is the tried offset with the strictly lowest error. On a tie the earlier tried offset wins, which is the smaller magnitude, and -k before +k. `lagOut` holds the kept lag for the rest of the beat.
- R4: Amplitude is tuned first, with the phase code at 2^(COEF_W-1). Phase is tuned second, with amplitude at its tuned value. The lag stays at the kept lag during both passes.
- R5: Each coefficient pass evaluates code 0, then code 2^COEF_W-1, then the midpoint floor((lo+hi)/2) of the current interval. When errLo <= errHi the midpoint replaces hi, otherwise it replaces lo. The pass ends when hi-lo <= 1 and keeps lo if errLo <= errHi, else hi. A pass uses at most COEF_W+2 evaluations.
- R6: While `evalReq` is high, `lagOut`, `ampOut` and `phaseOut` are stable until `errValid` is seen. `errValid` while `evalReq` is low changes nothing.
- R7: With `done`, `fitErr` holds the lower of the two final endpoint errors of the phase pass.
- R8: After reset `threshold` is all ones and `thrValid` is 0. When the CAL_BEATS-th calibration beat completes, `threshold` becomes floor(2*sum/CAL_BEATS) of those beats' `fitErr`, and `thrValid` rises and stays high.
- R9: With `done`, `unknown` is 1 for an ordinary beat whose `fitErr` is greater than `threshold`, and 0 otherwise. It is always 0 for a calibration beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin fitting one beat |
| calMode | input | 1 | Sampled with start: beat is a calibration beat |
| errValid | input | 1 | Error result for the pending evaluation is on errIn |
| errIn | input | ERR_W | Squared error from the distance engine |
| evalReq | output | 1 | An evaluation at the presented settings is pending |
| busy | output | 1 | A beat is being fitted |
| lagOut | output | clog2(LAG_RADIUS+1)+1 | Signed sample lag presented to the engine |
| ampOut | output | COEF_W | Centre-tap amplitude code |
| phaseOut | output | COEF_W | Outer-tap phase code (offset binary) |
| done | output | 1 | One-cycle pulse when a beat's fit is complete |
| fitErr | output | ERR_W | Final fitted error of the last beat |
| unknown | output | 1 | Classification label of the last beat |
| threshold | output | ERR_W+1 | Classification threshold |
| thrValid | output | 1 | Calibration has produced a threshold |

## Verification
The beats use a separable V-shaped error surface with a chosen optimum lag, amplitude and phase. Optimum lags inside, at and beyond the search radius show whether the order and edge of the lag search are right. Flat surfaces and surfaces with two equal minima on opposite sides expose wrong tie-breaking, in both the lag search and the bisection. Optima near each code extreme show whether the interval update keeps the correct half. A full calibration run, followed by beats above and below the computed threshold, separates a wrong mean, doubling or label rule. The varying response latency and a spurious start or idle error strobe show whether the handshake is respected.

// File: rtl/adseq_pkg.sv
package adseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LAG, S_INIT, S_LO, S_HI, S_CHK, S_MID, S_FIN
  } seqState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic beatBegin;  // clear search state, unity mapping
    logic lagTake;    // consume an error from the lag search
    logic bisInit;    // apply kept lag, open full code interval
    logic loTake;     // consume error at the low endpoint
    logic hiTake;     // consume error at the high endpoint
    logic midSet;     // present the interval midpoint
    logic midTake;    // consume midpoint error, shrink interval
    logic pick;       // settle the coefficient on the better endpoint
    logic finish;     // publish result, label, calibration
    logic tunePhase;  // 0: amplitude pass, 1: phase pass
  } adseqStrobe_t;

endpackage

// File: rtl/adseq_ctrl.sv
module adseq_ctrl
  import adseq_pkg::*;
#(
  parameter int LAG_RADIUS = 2,
  parameter int COEF_W     = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         errValid,
  input  logic         lagLast,
  input  logic         narrow,
  output adseqStrobe_t strb,
  output logic         evalReq,
  output logic         busy
);

  localparam int MAX_EVALS = 2 * LAG_RADIUS + 1 + 2 * (COEF_W + 2);
  localparam int CNT_W     = $clog2(MAX_EVALS + 1) + 1;

  seqState_t state, stateNext;
  logic      tunePhaseQ;
  logic [CNT_W-1:0] evalCnt;

  always_comb begin
    strb           = '0;
    strb.tunePhase = tunePhaseQ;
    stateNext      = state;
    unique case (state)
      S_IDLE: if (start) begin
        strb.beatBegin = 1'b1;
        stateNext      = S_LAG;
      end
      S_LAG: if (errValid) begin
        strb.lagTake = 1'b1;
        if (lagLast) stateNext = S_INIT;
      end
      S_INIT: begin
        strb.bisInit = 1'b1;
        stateNext    = S_LO;
      end
      S_LO: if (errValid) begin
        strb.loTake = 1'b1;
        stateNext   = S_HI;
      end
      S_HI: if (errValid) begin
        strb.hiTake = 1'b1;
        stateNext   = S_CHK;
      end
      S_CHK: begin
        if (narrow) begin
          strb.pick = 1'b1;
          stateNext = tunePhaseQ ? S_FIN : S_INIT;
        end else begin
          strb.midSet = 1'b1;
          stateNext   = S_MID;
        end
      end
      S_MID: if (errValid) begin
        strb.midTake = 1'b1;
        stateNext    = S_CHK;
      end
      S_FIN: begin
        strb.finish = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      tunePhaseQ <= 1'b0;
      evalCnt    <= '0;
    end else begin
      state <= stateNext;
      if (strb.beatBegin) tunePhaseQ <= 1'b0;
      else if (state == S_CHK && narrow && !tunePhaseQ) tunePhaseQ <= 1'b1;
      if (strb.beatBegin) evalCnt <= '0;
      else if (evalReq && errValid) evalCnt <= evalCnt + 1'b1;
    end
  end

  assign evalReq = (state == S_LAG) || (state == S_LO) ||
                   (state == S_HI)  || (state == S_MID);
  assign busy    = (state != S_IDLE);

  // R5
  eval_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    evalCnt <= CNT_W'(MAX_EVALS));

endmodule

// File: rtl/adseq_dp.sv
module adseq_dp
  import adseq_pkg::*;
#(
  parameter int LAG_RADIUS = 2,
  parameter int COEF_W     = 7,
  parameter int ERR_W      = 16,
  parameter int CAL_BEATS  = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  adseqStrobe_t             strb,
  input  logic                     calMode,
  input  logic [ERR_W-1:0]         errIn,
  output logic                     lagLast,
  output logic                     narrow,
  output logic signed [$clog2(LAG_RADIUS+1):0] lagOut,
  output logic [COEF_W-1:0]        ampOut,
  output logic [COEF_W-1:0]        phaseOut,
  output logic                     done,
  output logic [ERR_W-1:0]         fitErr,
  output logic                     unknown,
  output logic [ERR_W:0]           threshold,
  output logic                     thrValid
);

  localparam int LAG_W    = $clog2(LAG_RADIUS + 1) + 1;
  localparam int IDX_W    = $clog2(2 * LAG_RADIUS + 1);
  localparam int THR_W    = ERR_W + 1;
  localparam int CNT_W    = $clog2(CAL_BEATS) + 1;
  localparam int SUM_W    = ERR_W + CNT_W;
  localparam logic [COEF_W-1:0] CODE_MAX = '1;
  localparam logic [COEF_W-1:0] MID_CODE = COEF_W'(1) << (COEF_W - 1);

  function automatic logic signed [LAG_W-1:0] idxToLag(input int idx);
    int v;
    if (idx == 0)       v = 0;
    else if (idx % 2)   v = -((idx + 1) / 2);
    else                v = idx / 2;
    return LAG_W'(v);
  endfunction

  logic [IDX_W-1:0]        lagIdx;
  logic signed [LAG_W-1:0] lagQ, bestLag;
  logic [ERR_W-1:0]        runErr, fLo, fHi;
  logic [COEF_W-1:0]       ampQ, phQ, lo, hi, mid, coefVal;
  logic [COEF_W:0]         midSum;
  logic                    coefWr, calFlag, loWins;
  logic [SUM_W-1:0]        calSum, sumNext;
  logic [SUM_W:0]          quot;
  logic [CNT_W-1:0]        calCnt;

  assign lagLast = (lagIdx == IDX_W'(2 * LAG_RADIUS));
  assign narrow  = (hi - lo) <= COEF_W'(1);
  assign midSum  = {1'b0, lo} + {1'b0, hi};
  assign mid     = midSum[COEF_W:1];
  assign loWins  = (fLo <= fHi);
  assign sumNext = calSum + SUM_W'(runErr);
  assign quot    = {sumNext, 1'b0} / (SUM_W + 1)'(CAL_BEATS);

  always_comb begin
    coefWr  = 1'b1;
    coefVal = '0;
    if (strb.bisInit)     coefVal = '0;
    else if (strb.loTake) coefVal = CODE_MAX;
    else if (strb.midSet) coefVal = mid;
    else if (strb.pick)   coefVal = loWins ? lo : hi;
    else                  coefWr  = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lagIdx <= '0;  lagQ <= '0;  bestLag <= '0;  runErr <= '1;
      ampQ <= MID_CODE;  phQ <= MID_CODE;
      lo <= '0;  hi <= CODE_MAX;  fLo <= '0;  fHi <= '0;
      calFlag <= 1'b0;  calSum <= '0;  calCnt <= '0;
      fitErr <= '0;  unknown <= 1'b0;  done <= 1'b0;
      threshold <= '1;  thrValid <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.beatBegin) begin
        lagIdx <= '0;  lagQ <= '0;  bestLag <= '0;  runErr <= '1;
        ampQ <= MID_CODE;  phQ <= MID_CODE;  calFlag <= calMode;
      end
      if (strb.lagTake) begin
        if (errIn < runErr) begin
          runErr  <= errIn;
          bestLag <= lagQ;
        end
        if (!lagLast) begin
          lagIdx <= lagIdx + 1'b1;
          lagQ   <= idxToLag(int'(lagIdx) + 1);
        end
      end
      if (strb.bisInit) begin
        lagQ <= bestLag;  lo <= '0;  hi <= CODE_MAX;
      end
      if (strb.loTake) fLo <= errIn;
      if (strb.hiTake) fHi <= errIn;
      if (strb.midTake) begin
        if (loWins) begin hi <= mid;  fHi <= errIn; end
        else        begin lo <= mid;  fLo <= errIn; end
      end
      if (strb.pick) runErr <= loWins ? fLo : fHi;
      if (coefWr) begin
        if (strb.tunePhase) phQ  <= coefVal;
        else                ampQ <= coefVal;
      end
      if (strb.finish) begin
        fitErr <= runErr;
        done   <= 1'b1;
        if (calFlag) begin
          unknown <= 1'b0;
          if (calCnt == CNT_W'(CAL_BEATS - 1)) begin
            threshold <= THR_W'(quot);
            thrValid  <= 1'b1;
            calSum    <= '0;
            calCnt    <= '0;
          end else begin
            calSum <= sumNext;
            calCnt <= calCnt + 1'b1;
          end
        end else begin
          unknown <= ({1'b0, runErr} > threshold);
        end
      end
    end
  end

  assign lagOut   = lagQ;
  assign ampOut   = ampQ;
  assign phaseOut = phQ;

  // R2
  unity_during_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lagTake |-> (ampQ == MID_CODE && phQ == MID_CODE));

  // R2
  lag_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lagQ <= LAG_W'(LAG_RADIUS)) && (lagQ >= -LAG_W'(LAG_RADIUS)));

  // R5
  interval_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    lo < hi);

  // R8
  thr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    thrValid |=> thrValid);

endmodule

// File: rtl/adapt_seq.sv
module adapt_seq
  import adseq_pkg::*;
#(
  parameter int LAG_RADIUS = 2,
  parameter int COEF_W     = 7,
  parameter int ERR_W      = 16,
  parameter int CAL_BEATS  = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  calMode,
  input  logic                  errValid,
  input  logic [ERR_W-1:0]      errIn,
  output logic                  evalReq,
  output logic                  busy,
  output logic signed [$clog2(LAG_RADIUS+1):0] lagOut,
  output logic [COEF_W-1:0]     ampOut,
  output logic [COEF_W-1:0]     phaseOut,
  output logic                  done,
  output logic [ERR_W-1:0]      fitErr,
  output logic                  unknown,
  output logic [ERR_W:0]        threshold,
  output logic                  thrValid
);

  adseqStrobe_t strb;
  logic         lagLast, narrow;

  adseq_ctrl #(.LAG_RADIUS(LAG_RADIUS), .COEF_W(COEF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .errValid(errValid),
    .lagLast(lagLast), .narrow(narrow), .strb(strb),
    .evalReq(evalReq), .busy(busy)
  );

  adseq_dp #(.LAG_RADIUS(LAG_RADIUS), .COEF_W(COEF_W), .ERR_W(ERR_W),
             .CAL_BEATS(CAL_BEATS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .calMode(calMode), .errIn(errIn),
    .lagLast(lagLast), .narrow(narrow), .lagOut(lagOut), .ampOut(ampOut),
    .phaseOut(phaseOut), .done(done), .fitErr(fitErr), .unknown(unknown),
    .threshold(threshold), .thrValid(thrValid)
  );

  // R6
  hold_while_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evalReq && !errValid) |=> (evalReq && $stable(lagOut) &&
                                $stable(ampOut) && $stable(phaseOut)));

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/tb_adapt_seq.sv
module tb_adapt_seq;

  localparam int R     = 2;
  localparam int CW    = 7;
  localparam int EW    = 16;
  localparam int NCAL  = 20;
  localparam int LW    = $clog2(R + 1) + 1;
  localparam int UNITY = 64;
  localparam int CMAX  = 127;
  localparam int NV    = 6;
  // lag2x, lagW, ampOpt, ampW, phOpt, phW, base, extraStart
  localparam int TBL [NV][8] = '{
    '{ 2, 30,  70, 3,  64, 2,  50, 0},
    '{-4, 25,  20, 1, 100, 4,  10, 0},
    '{ 0,  0, 127, 2,   0, 2,   0, 0},
    '{-1, 20,  64, 0,  64, 0,   5, 0},
    '{ 8, 10,  33, 5,  90, 1,   7, 1},
    '{-3, 15,   1, 2, 126, 3, 200, 0}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, calMode = 1'b0;
  logic errValid = 1'b0;
  logic [EW-1:0] errIn = '0;
  logic evalReq, busy, done, unknown, thrValid;
  logic signed [LW-1:0] lagOut;
  logic [CW-1:0] ampOut, phaseOut;
  logic [EW-1:0] fitErr;
  logic [EW:0] threshold;

  adapt_seq dut (.clk(clk), .rstN(rstN), .start(start), .calMode(calMode),
    .errValid(errValid), .errIn(errIn), .evalReq(evalReq), .busy(busy),
    .lagOut(lagOut), .ampOut(ampOut), .phaseOut(phaseOut), .done(done),
    .fitErr(fitErr), .unknown(unknown), .threshold(threshold),
    .thrValid(thrValid));

  always #2.5 clk = ~clk;

  int nChk = 0, nFail = 0;
  int cL2, cLw, cA, cAw, cP, cPw, cBase;
  int expLag[64], expAmp[64], expPh[64];
  int expN, mLag, mAmp, mPh, mErr;
  int obsLag[4096], obsAmp[4096], obsPh[4096];
  int obsN = 0, pokeReq = 0, pokeDone = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int errModel(input int lag, input int a, input int p);
    return cBase + cLw * iabs(2 * lag - cL2) + cAw * iabs(a - cA) + cPw * iabs(p - cP);
  endfunction

  task automatic rec(input int l, input int a, input int p);
    expLag[expN] = l; expAmp[expN] = a; expPh[expN] = p; expN++;
  endtask

  task automatic bisect(input bit ph, output int code, output int err);
    int lo = 0, hi = CMAX, fl, fh, fm, md;
    rec(mLag, ph ? mAmp : 0, ph ? 0 : UNITY);
    fl = ph ? errModel(mLag, mAmp, 0) : errModel(mLag, 0, UNITY);
    rec(mLag, ph ? mAmp : CMAX, ph ? CMAX : UNITY);
    fh = ph ? errModel(mLag, mAmp, CMAX) : errModel(mLag, CMAX, UNITY);
    while (hi - lo > 1) begin
      md = (lo + hi) / 2;
      rec(mLag, ph ? mAmp : md, ph ? md : UNITY);
      fm = ph ? errModel(mLag, mAmp, md) : errModel(mLag, md, UNITY);
      if (fl <= fh) begin hi = md; fh = fm; end
      else begin lo = md; fl = fm; end
    end
    code = (fl <= fh) ? lo : hi;
    err  = (fl <= fh) ? fl : fh;
  endtask

  task automatic modelBeat();
    int best = 32'h7fffffff, off, e;
    expN = 0; mLag = 0;
    for (int i = 0; i <= 2 * R; i++) begin
      off = (i == 0) ? 0 : ((i % 2) ? -((i + 1) / 2) : i / 2);
      rec(off, UNITY, UNITY);
      e = errModel(off, UNITY, UNITY);
      if (e < best) begin best = e; mLag = off; end
    end
    bisect(1'b0, mAmp, e);
    bisect(1'b1, mPh, mErr);
  endtask

  // distance-engine stand-in with varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (pokeReq != pokeDone) begin
        errValid = 1'b1; errIn = 16'h0001;
        @(negedge clk);
        errValid = 1'b0;
        pokeDone++;
      end else if (evalReq) begin
        int l, a, p, e;
        l = lagOut; a = ampOut; p = phaseOut;
        obsLag[obsN] = l; obsAmp[obsN] = a; obsPh[obsN] = p;
        e = errModel(l, a, p);
        repeat (obsN % 3) @(negedge clk);
        obsN++;
        errValid = 1'b1; errIn = EW'(e);
        @(negedge clk);
        errValid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  task automatic runBeat(input bit cal, input bit extra, input bit full);
    int base0, bad2, bad45;
    modelBeat();
    base0 = obsN;
    @(negedge clk);
    calMode = cal; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (full) check(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    if (extra) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (full) begin
      check(busy == 1'b0, "R1", "busy with done", int'(busy), 0);
      check(obsN - base0 == expN, "R5", "eval count", obsN - base0, expN);
      bad2 = 0; bad45 = 0;
      for (int k = 0; k < expN; k++) begin
        bit m;
        m = obsLag[base0+k] != expLag[k] || obsAmp[base0+k] != expAmp[k] ||
            obsPh[base0+k] != expPh[k];
        if (m && k <= 2 * R) bad2++;
        if (m && k > 2 * R) bad45++;
      end
      check(bad2 == 0, "R2", "lag search order/unity", bad2, 0);
      check(bad45 == 0, "R4", "coefficient pass sequence (R5)", bad45, 0);
      check(int'(lagOut) == mLag, "R3", "kept lag", int'(lagOut), mLag);
      check(int'(ampOut) == mAmp, "R5", "amplitude code", int'(ampOut), mAmp);
      check(int'(phaseOut) == mPh, "R5", "phase code", int'(phaseOut), mPh);
      check(int'(fitErr) == mErr, "R7", "fitted error", int'(fitErr), mErr);
    end
    @(negedge clk);
    if (full) check(done == 1'b0, "R1", "done single pulse", int'(done), 0);
  endtask

  task automatic setBeat(input int l2, input int lw, input int a, input int aw,
                         input int p, input int pw, input int b);
    cL2 = l2; cLw = lw; cA = a; cAw = aw; cP = p; cPw = pw; cBase = b;
  endtask

  initial begin
    int calSum, expThr;
    logic [EW-1:0] keepErr;
    logic signed [LW-1:0] keepLag;
    setBeat(0, 1, 64, 1, 64, 1, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && evalReq == 1'b0 && done == 1'b0, "R1",
          "reset idle", int'({busy, evalReq, done}), 0);
    check(thrValid == 1'b0 && threshold == '1, "R8", "reset threshold",
          int'(threshold), 131071);
    check(ampOut == 7'd64 && phaseOut == 7'd64 && lagOut == 0, "R2",
          "reset unity mapping", int'(ampOut), 64);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      setBeat(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4],
              TBL[v][5], TBL[v][6]);
      runBeat(1'b0, TBL[v][7] != 0, 1'b1);
      check(unknown == 1'b0, "R9", "label before calibration", int'(unknown), 0);
    end

    // R6: error strobe while idle
    keepErr = fitErr; keepLag = lagOut;
    pokeReq++;
    while (pokeDone != pokeReq) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && fitErr == keepErr && lagOut == keepLag, "R6",
          "idle errValid ignored", int'(fitErr), int'(keepErr));

    // R8 calibration run
    calSum = 0;
    for (int i = 0; i < NCAL; i++) begin
      setBeat((i % 5) - 2, 10, 40 + i, 1, 60 + i, 1, 100 + 3 * i);
      runBeat(1'b1, 1'b0, 1'b0);
      calSum += mErr;
      check(unknown == 1'b0, "R9", "calibration beat label", int'(unknown), 0);
      if (i == NCAL - 2)
        check(thrValid == 1'b0, "R8", "no threshold before last", int'(thrValid), 0);
    end
    expThr = (2 * calSum) / NCAL;
    check(thrValid == 1'b1, "R8", "threshold valid", int'(thrValid), 1);
    check(int'(threshold) == expThr, "R8", "threshold value", int'(threshold), expThr);

    // R9 labels against the threshold
    setBeat(0, 10, 64, 1, 64, 1, 5000);
    runBeat(1'b0, 1'b0, 1'b1);
    check(unknown == (mErr > expThr), "R9", "high error label", int'(unknown), 1);
    setBeat(0, 10, 64, 1, 64, 1, 10);
    runBeat(1'b0, 1'b0, 1'b1);
    check(unknown == (mErr > expThr), "R9", "low error label", int'(unknown), 0);
    setBeat(0, 0, 0, 0, 0, 0, expThr);
    runBeat(1'b0, 1'b0, 1'b1);
    check(unknown == 1'b0, "R9", "error equal to threshold", int'(unknown), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule